// File: doc/BRIEF.md
# Dual-Memory Fixed-Point FIR Multiply-Accumulate Datapath

This block computes one output of a finite impulse response filter as the sum of coefficient-times-sample products. It keeps coefficients and samples in two separate small memories, each with its own address and data path. On every working cycle it reads one coefficient and one sample together. The two operands are latched into a pair of signed input registers in front of a multiplier, and each product is added into a wide accumulator. When all the requested taps have been summed, a shift stage scales the accumulator up or down by a programmable number of bits. It then clamps the value to the output width and holds it on the result port.

Samples enter through a write strobe and are stored in a circular buffer, so no stored word ever moves. Tap 0 always refers to the newest sample, tap 1 to the one before it, and so on. Coefficients are written by address. A one-cycle start pulse launches a computation, and a one-cycle done pulse reports the result.

Top module: `fir_mac_core`

## Requirements
- R1: After reset, busy_o, done_o and result_o are 0, and every word of both the coefficient memory and the sample memory reads as 0.
- R2: A cycle with coef_we_i high stores coef_data_i at coefficient index coef_addr_i (index k multiplies tap k), without touching the sample memory.
- R3: Each cycle with sample_we_i high stores sample_i as the newest sample. Tap k uses the sample written k writes earlier, and only the last DEPTH (16) samples are kept.
- R4: A start accepted while idle clears the accumulator and forms the sum over k < N of coef[k] * x(n-k). Operands are signed 16-bit and the sum is kept in a 32-bit two's complement accumulator that wraps.
- R5: done_o is a one-cycle pulse exactly N+2 clock edges after the edge that accepted start, where N is the effective tap count (N = 0 gives result 0). busy_o is high from the accepting edge until done_o rises.
- R6: A tap_count_i above DEPTH is treated as DEPTH.
- R7: With shift_left_i = 0, the accumulator is arithmetically shifted right by shift_amt_i bits, which rounds toward minus infinity.
- R8: With shift_left_i = 1, the accumulator is multiplied by 2^shift_amt_i without losing upper bits before clamping.
- R9: The scaled value is saturated to the signed 16-bit range [-32768, 32767] and never wraps.
- R10: start_i while busy is ignored. tap_count_i, shift_left_i and shift_amt_i are taken only at the accepting edge.
- R11: result_o changes only on the edge that raises done_o and otherwise holds its value, including across memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| tap_count_i | input | 5 | Number of taps N (0..31, clamped to 16) |
| shift_left_i | input | 1 | 1 = scale up, 0 = scale down |
| shift_amt_i | input | 5 | Shift distance in bits |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 4 | Coefficient index |
| coef_data_i | input | 16 | Coefficient value, signed |
| sample_we_i | input | 1 | Sample push strobe |
| sample_i | input | 16 | Sample value, signed |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 16 | Scaled, saturated result, signed |

## Verification
The bench pushes more samples than the buffer holds, then picks one tap with a single-coefficient pattern. A wrong circular address would return a stale or shifted sample. A sum of -3 shifted right by one must give -2. A logical shift or a truncating divide would give a large positive value or -1 instead. Large left shifts and full-scale products are driven into the clamp, where a wrapping design gives sign-flipped garbage. A second start and a changed shift amount are applied mid-run: a design that re-samples them stretches the latency or rescales the result.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_OUT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/fir_tap_mem.sv
module fir_tap_mem #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq
  import fir_mac_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SHIFT_W = 5,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   tap_count_i,
  input  logic               shift_left_i,
  input  logic [SHIFT_W-1:0] shift_amt_i,
  input  logic [ADDR_W-1:0]  newest_i,
  output logic [ADDR_W-1:0]  coef_addr_o,
  output logic [ADDR_W-1:0]  smp_addr_o,
  output logic               clr_o,
  output logic               issue_o,
  output logic               out_en_o,
  output logic               busy_o,
  output logic               left_o,
  output logic [SHIFT_W-1:0] amt_o
);
  seq_state_e         state_q;
  logic [CNT_W-1:0]   idx_q, cnt_q, eff_cnt;
  logic [ADDR_W-1:0]  base_q;
  logic               accept;

  assign eff_cnt = (tap_count_i > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : tap_count_i;
  assign accept  = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      left_o  <= 1'b0;
      amt_o   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q   <= '0;
          cnt_q   <= eff_cnt;
          base_q  <= newest_i;
          left_o  <= shift_left_i;
          amt_o   <= shift_amt_i;
          state_q <= (eff_cnt == '0) ? ST_DRAIN : ST_ISSUE;
        end
        ST_ISSUE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_OUT;
        ST_OUT:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // tap k reads coef[k] and the sample k pushes before the newest one
  assign coef_addr_o = idx_q[ADDR_W-1:0];
  assign smp_addr_o  = base_q - idx_q[ADDR_W-1:0];
  assign clr_o       = accept;
  assign issue_o     = (state_q == ST_ISSUE);
  assign out_en_o    = (state_q == ST_OUT);
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    issue_i,
  input  logic [DATA_W-1:0]       coef_i,
  input  logic [DATA_W-1:0]       smp_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [DATA_W-1:0] op_a_q, op_b_q;
  logic                     vld_q;
  logic signed [PROD_W-1:0] prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q <= '0;
      op_b_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= issue_i;
      if (issue_i) begin
        op_a_q <= $signed(coef_i);
        op_b_q <= $signed(smp_i);
      end
    end
  end

  assign prod = op_a_q * op_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clr_i)   acc_o <= '0;
    else if (vld_q)   acc_o <= acc_o + ACC_W'(prod);
  end
endmodule

// File: rtl/fir_scale_unit.sv
module fir_scale_unit #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 5,
  localparam int EXT_W  = ACC_W + (1 << SHIFT_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    out_en_i,
  input  logic                    left_i,
  input  logic [SHIFT_W-1:0]      amt_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [DATA_W-1:0]       result_o,
  output logic                    done_o
);
  localparam logic signed [EXT_W-1:0] SAT_HI =
    {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] SAT_LO =
    {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [EXT_W-1:0] ext, shifted;
  logic [DATA_W-1:0]       clamped;

  // widened first so a left shift cannot drop significant bits before the clamp
  assign ext     = EXT_W'(acc_i);
  assign shifted = left_i ? (ext <<< amt_i) : (ext >>> amt_i);

  always_comb begin
    if (shifted > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
    else if (shifted < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
    else                       clamped = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= out_en_i;
      if (out_en_i) result_o <= clamped;
    end
  end
endmodule

// File: rtl/fir_mac_core.sv
module fir_mac_core #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int SHIFT_W = 5,
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   tap_count_i,
  input  logic               shift_left_i,
  input  logic [SHIFT_W-1:0] shift_amt_i,
  input  logic               coef_we_i,
  input  logic [ADDR_W-1:0]  coef_addr_i,
  input  logic [DATA_W-1:0]  coef_data_i,
  input  logic               sample_we_i,
  input  logic [DATA_W-1:0]  sample_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  result_o
);
  logic [ADDR_W-1:0]       wr_ptr_q, newest;
  logic [ADDR_W-1:0]       coef_raddr, smp_raddr;
  logic [DATA_W-1:0]       coef_rd, smp_rd;
  logic                    clr, issue, out_en, left;
  logic [SHIFT_W-1:0]      amt;
  logic signed [ACC_W-1:0] acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wr_ptr_q <= '0;
    else if (sample_we_i) wr_ptr_q <= wr_ptr_q + 1'b1;
  end
  assign newest = wr_ptr_q - 1'b1;

  fir_tap_mem #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_coef_mem (
    .clk_i, .rst_ni,
    .we_i(coef_we_i), .waddr_i(coef_addr_i), .wdata_i(coef_data_i),
    .raddr_i(coef_raddr), .rdata_o(coef_rd)
  );

  fir_tap_mem #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_smp_mem (
    .clk_i, .rst_ni,
    .we_i(sample_we_i), .waddr_i(wr_ptr_q), .wdata_i(sample_i),
    .raddr_i(smp_raddr), .rdata_o(smp_rd)
  );

  fir_mac_seq #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .tap_count_i, .shift_left_i, .shift_amt_i,
    .newest_i(newest), .coef_addr_o(coef_raddr), .smp_addr_o(smp_raddr),
    .clr_o(clr), .issue_o(issue), .out_en_o(out_en), .busy_o(busy_o),
    .left_o(left), .amt_o(amt)
  );

  fir_mac_unit #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni, .clr_i(clr), .issue_i(issue),
    .coef_i(coef_rd), .smp_i(smp_rd), .acc_o(acc)
  );

  fir_scale_unit #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_scale (
    .clk_i, .rst_ni, .out_en_i(out_en), .left_i(left), .amt_i(amt),
    .acc_i(acc), .result_o(result_o), .done_o(done_o)
  );
endmodule

// File: rtl/fir_mac_core_chk.sv
module fir_mac_core_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o
);
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_done_ends_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_busy_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

bind fir_mac_core fir_mac_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/fir_mac_core_tb.sv
module fir_mac_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  tap_count_i = '0;
  logic        shift_left_i = 1'b0;
  logic [4:0]  shift_amt_i = '0;
  logic        coef_we_i = 1'b0;
  logic [3:0]  coef_addr_i = '0;
  logic [15:0] coef_data_i = '0;
  logic        sample_we_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic        busy_o, done_o;
  logic [15:0] result_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  fir_mac_core u_dut (.*);

  logic signed [15:0] coef_m [16];
  logic signed [15:0] hist [256];
  int hcnt = 0;

  // stimulus table: {tap count, shift_left, shift amount}
  localparam logic [10:0] VEC [10] = '{
    {5'd16, 1'b0, 5'd10}, {5'd16, 1'b0, 5'd0}, {5'd5, 1'b0, 5'd4},
    {5'd1, 1'b0, 5'd0},  {5'd8, 1'b1, 5'd2},  {5'd3, 1'b0, 5'd9},
    {5'd0, 1'b0, 5'd0},  {5'd12, 1'b0, 5'd31}, {5'd16, 1'b1, 5'd31},
    {5'd7, 1'b0, 5'd6}
  };

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint x_at(int k);
    return (k < hcnt) ? longint'(hist[hcnt-1-k]) : 0;
  endfunction

  function automatic longint model(int n, bit left, int amt);
    longint s = 0;
    int eff = (n > 16) ? 16 : n;
    for (int k = 0; k < eff; k++) s += longint'(coef_m[k]) * x_at(k);
    s = longint'(int'(s));
    s = left ? (s <<< amt) : (s >>> amt);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic wr_coef(int a, int v);
    @(negedge clk_i);
    coef_we_i = 1'b1; coef_addr_i = 4'(a); coef_data_i = 16'(v);
    @(negedge clk_i);
    coef_we_i = 1'b0;
    coef_m[a] = 16'(v);
  endtask

  task automatic push(int v);
    @(negedge clk_i);
    sample_we_i = 1'b1; sample_i = 16'(v);
    @(negedge clk_i);
    sample_we_i = 1'b0;
    hist[hcnt] = 16'(v);
    hcnt++;
  endtask

  task automatic run(int n, bit left, int amt, bit poke,
                     output longint res, output int lat);
    @(negedge clk_i);
    tap_count_i = 5'(n); shift_left_i = left; shift_amt_i = 5'(amt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
      if (poke && lat == 3) begin
        start_i = 1'b1; shift_amt_i = 5'(amt + 3); tap_count_i = 5'd1;
        shift_left_i = ~left;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    res = longint'($signed(result_o));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    longint res, exp, hold;
    int lat;
    for (int i = 0; i < 16; i++) coef_m[i] = '0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset busy/done", busy_o, 0);
    check(result_o == 16'd0, "R1 reset result", result_o, 0);
    rst_ni = 1'b1;

    // R1: coefficient memory reset -> zero
    push(5);
    run(16, 0, 0, 0, res, lat);
    check(res == 0, "R1 coef mem reset", res, 0);
    // R2: coef writes, sample memory reset to zero beyond the one push
    for (int i = 0; i < 16; i++) wr_coef(i, 1);
    run(16, 0, 0, 0, res, lat);
    check(res == 5, "R2 coef write / R1 sample mem reset", res, 5);

    for (int i = 0; i < 16; i++) wr_coef(i, 100 * i - 700);
    for (int i = 0; i < 20; i++) push((i * 1237) % 4000 - 2000);

    // R4 R5 R7 R8 R9 table walk
    foreach (VEC[v]) begin
      int n = int'(VEC[v][10:6]);
      bit l = VEC[v][5];
      int a = int'(VEC[v][4:0]);
      exp = model(n, l, a);
      run(n, l, a, 0, res, lat);
      check(res == exp, $sformatf("R4 vec%0d result", v), res, exp);
      check(lat == n + 2, $sformatf("R5 vec%0d latency", v), lat, n + 2);
    end

    // R6: tap count clamped to 16
    exp = model(16, 0, 8);
    run(31, 0, 8, 0, res, lat);
    check(res == exp, "R6 clamp result", res, exp);
    check(lat == 18, "R6 clamp latency", lat, 18);

    // R3: delta at tap 15 picks the sample 15 pushes back after wrap
    for (int i = 0; i < 16; i++) wr_coef(i, (i == 15) ? 1 : 0);
    exp = longint'(hist[hcnt-16]);
    run(16, 0, 0, 0, res, lat);
    check(res == exp, "R3 circular tap 15", res, exp);

    // R7: -3 >>> 1 = -2 (floor)
    for (int i = 0; i < 16; i++) wr_coef(i, (i == 0) ? -3 : 0);
    push(1);
    run(1, 0, 1, 0, res, lat);
    check(res == -2, "R7 arithmetic floor", res, -2);

    // R8: 1 << 14 exact, R9: 1 << 15 saturates
    wr_coef(0, 1);
    run(1, 1, 14, 0, res, lat);
    check(res == 16384, "R8 left shift", res, 16384);
    run(1, 1, 15, 0, res, lat);
    check(res == 32767, "R9 left shift saturate", res, 32767);

    // R9: full-scale products
    wr_coef(0, 32767);
    push(32767);
    run(1, 0, 0, 0, res, lat);
    check(res == 32767, "R9 positive saturate", res, 32767);
    push(-32768);
    run(1, 0, 0, 0, res, lat);
    check(res == -32768, "R9 negative saturate", res, -32768);

    // R10: restart and parameter changes mid-run ignored
    for (int i = 0; i < 16; i++) wr_coef(i, 3 * i - 20);
    exp = model(8, 0, 2);
    run(8, 0, 2, 1, res, lat);
    check(res == exp, "R10 mid-run start ignored result", res, exp);
    check(lat == 10, "R10 mid-run start ignored latency", lat, 10);
    @(negedge clk_i);
    check(busy_o == 1'b0, "R10 no second run", busy_o, 0);

    // R11: result held across memory writes
    hold = res;
    push(1234);
    wr_coef(0, 555);
    repeat (4) @(negedge clk_i);
    check(longint'($signed(result_o)) == hold, "R11 result hold",
          longint'($signed(result_o)), hold);
    check(done_o == 1'b0, "R5 done single pulse", done_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule